// File: doc/BRIEF.md
# Set-Associative Tag Cache Controller

This block is the tag and state side of a set-associative cache. It holds no data. It keeps the tags of resident blocks, a valid, dirty and prefetched flag per block, and a recency order per set. A client hands it one demand access at a time, each a byte address with a read/write flag. One cycle later the block answers hit or miss and raises the requests the next level must act on: a block fill read, a forwarded write, or the writeback of a dirty victim.

The size of the cache comes from three base-2 exponents: C for total bytes, B for block bytes and S for ways per set. Two choices are fixed at elaboration. The first is where a newly filled block enters its set's recency order, at the most recently used end or the least recently used end. The second is the write handling, either write-back with allocation or write-through without allocation. The LRU-end choice lets blocks that are touched once drop out quickly.

A second input port installs blocks brought in by a prefetcher. These blocks are marked as prefetched, so the first demand hit on one can be counted separately. Four free-running counters record demand hits, demand misses, writebacks and prefetch hits.

Top module: `tcache_ctrl`

## Requirements
- R1: An address is split into a block offset (bits B-1..0, ignored), a set index (the next C-B-S bits) and a tag (all higher bits). Two addresses in the same block always hit the same line, and addresses with different index bits never displace each other.
- R2: `req_ready` is high when the block is idle. A request taken with `req_valid` and `req_ready` both high produces `rsp_valid` with `rsp_hit` in the following cycle. Neither port is ready in that cycle. A prefetch is taken only when `pf_ready` is high, which needs an idle block and `req_valid` low.
- R3: A set holds up to 2^S distinct blocks. A hit moves its block to the most recent position. Empty ways are filled before any resident block is evicted, and the victim is always the least recently used block.
- R4: With LRU-end insertion, a filled block enters as least recently used. It is therefore the next victim in its full set unless it is hit first.
- R5: With MRU-end insertion, a filled block enters as most recently used.
- R6: In write-back mode, a write hit marks the block dirty and sends nothing downstream. A read or write miss raises `dn_rd_valid` with the block address (address bits above B) and allocates the block, which is dirty when the miss was a write.
- R7: In write-back mode, replacing a dirty block raises `dn_wb_valid` with that block's address ({tag, index}) and increments `cnt_wb` in the same cycle.
- R8: In write-through mode, every write raises `dn_wt_valid` with its byte address. A write hit updates recency, a write miss allocates nothing and raises no fill, and read misses allocate and fill as normal. No writeback is ever raised.
- R9: A prefetch fill of an absent block inserts it with the prefetched mark and the configured insertion policy, raising no response and no fill read. The first demand hit on that block increments `cnt_pf_hit` and clears the mark, so later hits do not count.
- R10: A prefetch fill of a block that is already resident changes neither the set contents, the recency order nor any mark.
- R11: `cnt_hit` and `cnt_miss` each increase by one for every demand hit and demand miss. They are visible in the response cycle.
- R12: After reset, every line is invalid, all counters read zero, no output request is raised and both ports are ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Demand request present |
| req_ready | output | 1 | Demand request can be taken |
| req_addr | input | ADDR_W | Demand byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | Lookup hit |
| pf_valid | input | 1 | Prefetch fill present |
| pf_ready | output | 1 | Prefetch fill can be taken |
| pf_addr | input | ADDR_W | Prefetch fill byte address |
| dn_rd_valid | output | 1 | Fill read to next level |
| dn_rd_blk | output | ADDR_W-B | Block address of fill read |
| dn_wt_valid | output | 1 | Forwarded write to next level |
| dn_wt_addr | output | ADDR_W | Byte address of forwarded write |
| dn_wb_valid | output | 1 | Dirty victim writeback |
| dn_wb_blk | output | ADDR_W-B | Block address of writeback |
| cnt_hit | output | CNT_W | Demand hit count |
| cnt_miss | output | CNT_W | Demand miss count |
| cnt_wb | output | CNT_W | Writeback count |
| cnt_pf_hit | output | CNT_W | First-hit-on-prefetched-line count |

## Verification
The assertions take for granted that the client never raises a request while the matching ready is low, and that address inputs are never unknown at a clock edge. The single-match and single-oldest checks rely on this, because they look at whichever set the current address selects. The stimulus keeps to these rules by holding every input at a defined value from time zero. It raises a request only after seeing the ready, and it drops the request at the first falling edge after the acceptance edge. Random traffic is confined to six tags across all sets, so conflicts, dirty evictions and repeated prefetches occur often, and directed sequences cover the insertion-order and prefetch-marking corner cases.

// File: rtl/tcache_pkg.sv
package tcache_pkg;

    // Position in the recency order taken by a newly installed block
    typedef enum logic {
        INS_AT_MRU = 1'b0,
        INS_AT_LRU = 1'b1
    } ins_pol_e;

    // Write handling
    typedef enum logic {
        WR_BACK_ALLOC   = 1'b0,
        WR_THRU_NOALLOC = 1'b1
    } wr_pol_e;

endpackage

// File: rtl/tcache_addr_split.sv
// Splits a block address (byte address without offset) into set index and tag.
module tcache_addr_split #(
    parameter int BLK_W = 26,
    parameter int IDX_W = 4,
    parameter int TAG_W = 22
) (
    input  logic [BLK_W-1:0] blk,
    output logic [IDX_W-1:0] idx,
    output logic [TAG_W-1:0] tag
);
    assign idx = blk[IDX_W-1:0];
    assign tag = blk[BLK_W-1:IDX_W];
endmodule

// File: rtl/tcache_way_pick.sv
// Tag match across the ways of one set, plus selection of the way to refill.
module tcache_way_pick #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 22,
    parameter int AGE_W = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [WAYS-1:0]            valid,
    input  logic [WAYS-1:0][TAG_W-1:0] tags,
    input  logic [WAYS-1:0][AGE_W-1:0] ages,
    input  logic [TAG_W-1:0]           look_tag,
    output logic                       hit,
    output logic [AGE_W-1:0]           hit_way,
    output logic [AGE_W-1:0]           fill_way
);
    logic [WAYS-1:0] match;
    logic [WAYS-1:0] is_old;

    generate
        for (genvar w = 0; w < WAYS; w++) begin : g_way
            assign match[w]  = valid[w] && (tags[w] == look_tag);
            assign is_old[w] = (ages[w] == AGE_W'(WAYS - 1));
        end
    endgenerate

    always_comb begin
        hit      = |match;
        hit_way  = '0;
        fill_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w]) hit_way = AGE_W'(w);
        end
        if (!(&valid)) begin
            // lowest-numbered empty way first
            for (int w = WAYS - 1; w >= 0; w--) begin
                if (!valid[w]) fill_way = AGE_W'(w);
            end
        end else begin
            for (int w = WAYS - 1; w >= 0; w--) begin
                if (is_old[w]) fill_way = AGE_W'(w);
            end
        end
    end

    AST_SINGLE_MATCH : assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match)); // R3
    AST_ONE_OLDEST : assert property (@(posedge clk) disable iff (!rst_n)
        $countones(is_old) == 1); // R3
endmodule

// File: rtl/tcache_age_update.sv
// Recency update for one set: age 0 is most recent, WAYS-1 least recent.
module tcache_age_update #(
    parameter int WAYS  = 4,
    parameter int AGE_W = 2
) (
    input  logic [WAYS-1:0][AGE_W-1:0] ages_in,
    input  logic [AGE_W-1:0]           sel,
    input  logic                       to_lru,
    output logic [WAYS-1:0][AGE_W-1:0] ages_out
);
    logic [AGE_W-1:0] sel_age;

    always_comb begin
        sel_age = ages_in[sel];
        for (int w = 0; w < WAYS; w++) begin
            if (AGE_W'(w) == sel) begin
                ages_out[w] = to_lru ? AGE_W'(WAYS - 1) : '0;
            end else if (!to_lru && (ages_in[w] < sel_age)) begin
                ages_out[w] = ages_in[w] + 1'b1;
            end else if (to_lru && (ages_in[w] > sel_age)) begin
                ages_out[w] = ages_in[w] - 1'b1;
            end else begin
                ages_out[w] = ages_in[w];
            end
        end
    end
endmodule

// File: rtl/tcache_ctrl.sv
module tcache_ctrl
    import tcache_pkg::*;
#(
    parameter int       ADDR_W  = 32,
    parameter int       C       = 10,
    parameter int       B       = 6,
    parameter int       S       = 2,
    parameter int       CNT_W   = 16,
    parameter ins_pol_e INS_POL = INS_AT_MRU,
    parameter wr_pol_e  WR_POL  = WR_BACK_ALLOC
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic                req_write,
    output logic                rsp_valid,
    output logic                rsp_hit,
    input  logic                pf_valid,
    output logic                pf_ready,
    input  logic [ADDR_W-1:0]   pf_addr,
    output logic                dn_rd_valid,
    output logic [ADDR_W-B-1:0] dn_rd_blk,
    output logic                dn_wt_valid,
    output logic [ADDR_W-1:0]   dn_wt_addr,
    output logic                dn_wb_valid,
    output logic [ADDR_W-B-1:0] dn_wb_blk,
    output logic [CNT_W-1:0]    cnt_hit,
    output logic [CNT_W-1:0]    cnt_miss,
    output logic [CNT_W-1:0]    cnt_wb,
    output logic [CNT_W-1:0]    cnt_pf_hit
);
    localparam int IDX_W = C - B - S;
    localparam int SETS  = 1 << IDX_W;
    localparam int WAYS  = 1 << S;
    localparam int AGE_W = (S > 0) ? S : 1;
    localparam int BLK_W = ADDR_W - B;
    localparam int TAG_W = BLK_W - IDX_W;
    localparam bit WB_MODE = (WR_POL == WR_BACK_ALLOC);

    typedef struct packed {
        logic             valid;
        logic             dirty;
        logic             pf;
        logic [TAG_W-1:0] tag;
    } line_t;

    typedef struct {
        line_t                      line [SETS][WAYS];
        logic [WAYS-1:0][AGE_W-1:0] age  [SETS];
        logic                       busy;
        logic                       rsp_valid;
        logic                       rsp_hit;
        logic                       rd_v;
        logic                       wt_v;
        logic                       wb_v;
        logic [BLK_W-1:0]           rd_blk;
        logic [BLK_W-1:0]           wb_blk;
        logic [ADDR_W-1:0]          wt_addr;
        logic [CNT_W-1:0]           c_hit;
        logic [CNT_W-1:0]           c_miss;
        logic [CNT_W-1:0]           c_wb;
        logic [CNT_W-1:0]           c_pfh;
    } state_t;

    state_t q, n;

    // Port handshake
    logic dem_fire, pf_fire;
    assign req_ready = !q.busy;
    assign pf_ready  = !q.busy && !req_valid;
    assign dem_fire  = req_valid && req_ready;
    assign pf_fire   = pf_valid && pf_ready;

    // Lookup of the addressed set
    logic [ADDR_W-1:0]          op_addr;
    logic [IDX_W-1:0]           op_idx;
    logic [TAG_W-1:0]           op_tag;
    logic [WAYS-1:0]            set_valid;
    logic [WAYS-1:0][TAG_W-1:0] set_tags;
    logic [WAYS-1:0][AGE_W-1:0] set_ages;
    logic                       lk_hit;
    logic [AGE_W-1:0]           lk_hit_way, lk_fill_way;
    logic [WAYS-1:0][AGE_W-1:0] age_promo, age_ins;

    assign op_addr = dem_fire ? req_addr : pf_addr;

    tcache_addr_split #(.BLK_W(BLK_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) i_split (
        .blk (op_addr[ADDR_W-1:B]),
        .idx (op_idx),
        .tag (op_tag)
    );

    always_comb begin
        set_ages = q.age[op_idx];
        for (int w = 0; w < WAYS; w++) begin
            set_valid[w] = q.line[op_idx][w].valid;
            set_tags[w]  = q.line[op_idx][w].tag;
        end
    end

    tcache_way_pick #(.WAYS(WAYS), .TAG_W(TAG_W), .AGE_W(AGE_W)) i_pick (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid    (set_valid),
        .tags     (set_tags),
        .ages     (set_ages),
        .look_tag (op_tag),
        .hit      (lk_hit),
        .hit_way  (lk_hit_way),
        .fill_way (lk_fill_way)
    );

    tcache_age_update #(.WAYS(WAYS), .AGE_W(AGE_W)) i_age_hit (
        .ages_in  (set_ages),
        .sel      (lk_hit_way),
        .to_lru   (1'b0),
        .ages_out (age_promo)
    );

    tcache_age_update #(.WAYS(WAYS), .AGE_W(AGE_W)) i_age_fill (
        .ages_in  (set_ages),
        .sel      (lk_fill_way),
        .to_lru   (INS_POL == INS_AT_LRU),
        .ages_out (age_ins)
    );

    // Next-state computation
    line_t hl, vic, new_ln;
    logic  do_ins;

    always_comb begin
        n           = q;
        n.busy      = dem_fire || pf_fire;
        n.rsp_valid = 1'b0;
        n.rsp_hit   = 1'b0;
        n.rd_v      = 1'b0;
        n.wt_v      = 1'b0;
        n.wb_v      = 1'b0;
        n.rd_blk    = op_addr[ADDR_W-1:B];
        n.wt_addr   = op_addr;
        hl          = q.line[op_idx][lk_hit_way];
        vic         = q.line[op_idx][lk_fill_way];
        new_ln      = '0;
        do_ins      = 1'b0;

        if (dem_fire) begin
            n.rsp_valid = 1'b1;
            n.rsp_hit   = lk_hit;
            if (lk_hit) begin
                n.c_hit = q.c_hit + 1'b1;
                if (hl.pf) begin
                    n.c_pfh = q.c_pfh + 1'b1;
                    hl.pf   = 1'b0;
                end
                if (req_write) begin
                    if (WB_MODE) hl.dirty = 1'b1;
                    else         n.wt_v   = 1'b1;
                end
                n.line[op_idx][lk_hit_way] = hl;
                n.age[op_idx]              = age_promo;
            end else begin
                n.c_miss = q.c_miss + 1'b1;
                if (req_write && !WB_MODE) begin
                    n.wt_v = 1'b1;
                end else begin
                    n.rd_v = 1'b1;
                    do_ins = 1'b1;
                    new_ln = '{valid: 1'b1, dirty: req_write, pf: 1'b0, tag: op_tag};
                end
            end
        end else if (pf_fire && !lk_hit) begin
            do_ins = 1'b1;
            new_ln = '{valid: 1'b1, dirty: 1'b0, pf: 1'b1, tag: op_tag};
        end

        if (do_ins) begin
            if (vic.valid && vic.dirty) begin
                n.wb_v   = 1'b1;
                n.wb_blk = {vic.tag, op_idx};
                n.c_wb   = q.c_wb + 1'b1;
            end
            n.line[op_idx][lk_fill_way] = new_ln;
            n.age[op_idx]               = age_ins;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    q.line[s][w]   <= '0;
                    q.age[s][w]    <= AGE_W'(w);
                end
            end
            q.busy      <= 1'b0;
            q.rsp_valid <= 1'b0;
            q.rsp_hit   <= 1'b0;
            q.rd_v      <= 1'b0;
            q.wt_v      <= 1'b0;
            q.wb_v      <= 1'b0;
            q.rd_blk    <= '0;
            q.wb_blk    <= '0;
            q.wt_addr   <= '0;
            q.c_hit     <= '0;
            q.c_miss    <= '0;
            q.c_wb      <= '0;
            q.c_pfh     <= '0;
        end else begin
            q <= n;
        end
    end

    assign rsp_valid   = q.rsp_valid;
    assign rsp_hit     = q.rsp_hit;
    assign dn_rd_valid = q.rd_v;
    assign dn_rd_blk   = q.rd_blk;
    assign dn_wt_valid = q.wt_v;
    assign dn_wt_addr  = q.wt_addr;
    assign dn_wb_valid = q.wb_v;
    assign dn_wb_blk   = q.wb_blk;
    assign cnt_hit     = q.c_hit;
    assign cnt_miss    = q.c_miss;
    assign cnt_wb      = q.c_wb;
    assign cnt_pf_hit  = q.c_pfh;

    AST_RSP_FOLLOWS : assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid); // R2
    AST_BUSY_AFTER_TAKE : assert property (@(posedge clk) disable iff (!rst_n)
        ((req_valid && req_ready) || (pf_valid && pf_ready)) |=> (!req_ready && !pf_ready)); // R2
    AST_PF_NO_RSP : assert property (@(posedge clk) disable iff (!rst_n)
        (pf_valid && pf_ready) |=> (!rsp_valid && !dn_rd_valid)); // R9
    AST_HIT_QUIET : assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit) |-> (!dn_rd_valid && !dn_wb_valid)); // R3
    AST_MISS_DOWNSTREAM : assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (dn_rd_valid || dn_wt_valid)); // R6
    AST_WB_COUNTED : assert property (@(posedge clk) disable iff (!rst_n)
        dn_wb_valid |-> (cnt_wb == CNT_W'($past(cnt_wb) + 1'b1))); // R7
    AST_PFH_WITH_HIT : assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cnt_pf_hit) |-> !$stable(cnt_hit)); // R9
    AST_HITMISS_STEP : assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (!$stable(cnt_hit) != !$stable(cnt_miss))); // R11

    generate
        if (!WB_MODE) begin : g_wt_chk
            AST_WT_NO_WB : assert property (@(posedge clk) disable iff (!rst_n)
                !dn_wb_valid); // R8
        end
    endgenerate
endmodule

// File: tb/test_tcache_ctrl.sv
`timescale 1ns/1ps
module test_tcache_ctrl;
    import tcache_pkg::*;

    localparam int AW   = 16;
    localparam int CC   = 8;
    localparam int BB   = 4;
    localparam int SS   = 2;
    localparam int CW   = 16;
    localparam int IDXW = CC - BB - SS;
    localparam int SETS = 1 << IDXW;
    localparam int WAYS = 1 << SS;
    localparam int BLKW = AW - BB;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr  = '0;
    logic          req_write = 1'b0;
    logic          pf_valid  = 1'b0;
    logic [AW-1:0] pf_addr   = '0;

    logic            rq_rdy [2];
    logic            pf_rdy [2];
    logic            rv     [2];
    logic            rh     [2];
    logic            rdv    [2];
    logic [BLKW-1:0] rdb    [2];
    logic            wtv    [2];
    logic [AW-1:0]   wta    [2];
    logic            wbv    [2];
    logic [BLKW-1:0] wbb    [2];
    logic [CW-1:0]   c_h    [2];
    logic [CW-1:0]   c_m    [2];
    logic [CW-1:0]   c_w    [2];
    logic [CW-1:0]   c_p    [2];

    // instance 0: MRU insertion, write-back; instance 1: LRU insertion, write-through
    tcache_ctrl #(.ADDR_W(AW), .C(CC), .B(BB), .S(SS), .CNT_W(CW),
                  .INS_POL(INS_AT_MRU), .WR_POL(WR_BACK_ALLOC)) i_tcache_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(rq_rdy[0]), .req_addr(req_addr), .req_write(req_write),
        .rsp_valid(rv[0]), .rsp_hit(rh[0]),
        .pf_valid(pf_valid), .pf_ready(pf_rdy[0]), .pf_addr(pf_addr),
        .dn_rd_valid(rdv[0]), .dn_rd_blk(rdb[0]), .dn_wt_valid(wtv[0]), .dn_wt_addr(wta[0]),
        .dn_wb_valid(wbv[0]), .dn_wb_blk(wbb[0]),
        .cnt_hit(c_h[0]), .cnt_miss(c_m[0]), .cnt_wb(c_w[0]), .cnt_pf_hit(c_p[0]));

    tcache_ctrl #(.ADDR_W(AW), .C(CC), .B(BB), .S(SS), .CNT_W(CW),
                  .INS_POL(INS_AT_LRU), .WR_POL(WR_THRU_NOALLOC)) i_tcache_ctrl_lw (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(rq_rdy[1]), .req_addr(req_addr), .req_write(req_write),
        .rsp_valid(rv[1]), .rsp_hit(rh[1]),
        .pf_valid(pf_valid), .pf_ready(pf_rdy[1]), .pf_addr(pf_addr),
        .dn_rd_valid(rdv[1]), .dn_rd_blk(rdb[1]), .dn_wt_valid(wtv[1]), .dn_wt_addr(wta[1]),
        .dn_wb_valid(wbv[1]), .dn_wb_blk(wbb[1]),
        .cnt_hit(c_h[1]), .cnt_miss(c_m[1]), .cnt_wb(c_w[1]), .cnt_pf_hit(c_p[1]));

    int  n_chk = 0;
    int  n_err = 0;
    bit  done  = 1'b0;

    // Reference model: per set a recency list, position 0 most recent
    int mtag   [2][SETS][WAYS];
    bit mdirty [2][SETS][WAYS];
    bit mpf    [2][SETS][WAYS];
    int mcnt   [2][SETS];
    int e_hit [2];
    int e_miss[2];
    int e_wb  [2];
    int e_pfh [2];

    task automatic chk(input string r, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", r, act, exp);
        end
    endtask

    function automatic int mk(input int tg, input int idx, input int off);
        return (tg << (BB + IDXW)) | (idx << BB) | off;
    endfunction

    task automatic m_move_front(input int m, input int s, input int p);
        int t; bit d; bit f;
        t = mtag[m][s][p]; d = mdirty[m][s][p]; f = mpf[m][s][p];
        for (int i = p; i > 0; i--) begin
            mtag[m][s][i] = mtag[m][s][i-1];
            mdirty[m][s][i] = mdirty[m][s][i-1];
            mpf[m][s][i] = mpf[m][s][i-1];
        end
        mtag[m][s][0] = t; mdirty[m][s][0] = d; mpf[m][s][0] = f;
    endtask

    task automatic m_insert(input int m, input int s, input int tg, input bit d, input bit f,
                            output bit wb, output int wbblk);
        int p;
        wb = 1'b0; wbblk = 0;
        if (mcnt[m][s] == WAYS) begin
            if (mdirty[m][s][WAYS-1]) begin
                wb = 1'b1;
                wbblk = (mtag[m][s][WAYS-1] << IDXW) | s;
                e_wb[m]++;
            end
            mcnt[m][s]--;
        end
        p = mcnt[m][s];
        mtag[m][s][p] = tg; mdirty[m][s][p] = d; mpf[m][s][p] = f;
        mcnt[m][s]++;
        if (m == 0) m_move_front(m, s, p);   // MRU insertion on instance 0
    endtask

    task automatic m_op(input int m, input bit is_pf, input bit wr, input int addr,
                        output bit h, output bit rd, output bit wt, output bit wb, output int wbblk);
        int s; int tg; int p; bit wbm;
        s = (addr >> BB) & (SETS - 1);
        tg = addr >> (BB + IDXW);
        wbm = (m == 0);
        h = 0; rd = 0; wt = 0; wb = 0; wbblk = 0; p = -1;
        for (int i = 0; i < mcnt[m][s]; i++) if (mtag[m][s][i] == tg) p = i;
        if (p >= 0) begin
            if (!is_pf) begin
                h = 1; e_hit[m]++;
                if (mpf[m][s][p]) begin e_pfh[m]++; mpf[m][s][p] = 0; end
                if (wr) begin
                    if (wbm) mdirty[m][s][p] = 1;
                    else wt = 1;
                end
                m_move_front(m, s, p);
            end
        end else if (is_pf) begin
            m_insert(m, s, tg, 1'b0, 1'b1, wb, wbblk);
        end else begin
            e_miss[m]++;
            if (wr && !wbm) wt = 1;
            else begin
                rd = 1;
                m_insert(m, s, tg, wr, 1'b0, wb, wbblk);
            end
        end
    endtask

    // One operation on both instances; ht0/ht1 name the requirement of the hit check
    task automatic do_op(input bit is_pf, input bit wr, input int addr,
                         input string ht0, input string ht1);
        bit h, rd, wt, wb; int wbblk;
        @(negedge clk);
        for (int m = 0; m < 2; m++) begin
            if (is_pf) chk("R2 pf_ready idle", pf_rdy[m], 1);
            else       chk("R2 req_ready idle", rq_rdy[m], 1);
        end
        if (is_pf) begin pf_valid = 1'b1; pf_addr = AW'(addr); end
        else begin req_valid = 1'b1; req_addr = AW'(addr); req_write = wr; end
        @(negedge clk);
        req_valid = 1'b0; pf_valid = 1'b0;
        for (int m = 0; m < 2; m++) begin
            m_op(m, is_pf, wr, addr, h, rd, wt, wb, wbblk);
            chk("R2 busy after take", rq_rdy[m] | pf_rdy[m], 0);
            if (is_pf) chk("R9 no response to prefetch", rv[m], 0);
            else begin
                chk("R2 rsp_valid", rv[m], 1);
                chk((m == 0) ? ht0 : ht1, rh[m], h);
            end
            chk((m == 0) ? "R6 fill read" : "R8 fill read", rdv[m], rd);
            if (rd) chk("R1 fill block address", rdb[m], addr >> BB);
            chk("R8 forwarded write", wtv[m], wt);
            if (wt) chk("R8 forwarded address", wta[m], addr);
            chk("R7 writeback", wbv[m], wb);
            if (wb) chk("R7 writeback address", wbb[m], wbblk);
            chk("R11 hit count", c_h[m], e_hit[m]);
            chk("R11 miss count", c_m[m], e_miss[m]);
            chk("R7 writeback count", c_w[m], e_wb[m]);
            chk("R9 prefetch hit count", c_p[m], e_pfh[m]);
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd1234));
        for (int m = 0; m < 2; m++) begin
            e_hit[m] = 0; e_miss[m] = 0; e_wb[m] = 0; e_pfh[m] = 0;
            for (int s = 0; s < SETS; s++) mcnt[m][s] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12: reset state
        for (int m = 0; m < 2; m++) begin
            chk("R12 hit count zero", c_h[m], 0);
            chk("R12 miss count zero", c_m[m], 0);
            chk("R12 wb count zero", c_w[m], 0);
            chk("R12 pf count zero", c_p[m], 0);
            chk("R12 no response", rv[m], 0);
            chk("R12 no downstream", rdv[m] | wtv[m] | wbv[m], 0);
            chk("R12 ready", rq_rdy[m] & pf_rdy[m], 1);
        end
        do_op(0, 0, mk(1, 0, 0), "R12 empty after reset", "R12 empty after reset");

        // R1: offset ignored, index separates
        do_op(0, 0, mk(1, 0, 5), "R1 same block", "R1 same block");
        do_op(0, 0, mk(1, 1, 0), "R1 other index", "R1 other index");
        do_op(0, 0, mk(1, 0, 15), "R1 index isolation", "R1 index isolation");

        // R3: empty ways used first, four blocks coexist
        for (int t = 1; t <= 4; t++) do_op(0, 0, mk(t, 2, 0), "R3 cold miss", "R3 cold miss");
        for (int t = 1; t <= 4; t++) do_op(0, 0, mk(t, 2, 3), "R3 all resident", "R3 all resident");

        // R4/R5: insertion position decides the next victim
        do_op(0, 0, mk(5, 2, 0), "R5 conflict miss", "R4 conflict miss");
        do_op(0, 0, mk(6, 2, 0), "R5 conflict miss", "R4 conflict miss");
        do_op(0, 0, mk(2, 2, 0), "R5 evicted by MRU fill", "R4 kept under LRU fill");
        do_op(0, 0, mk(5, 2, 0), "R5 kept under MRU fill", "R4 LRU fill evicted");

        // R6/R7/R8: write handling
        do_op(0, 1, mk(3, 3, 0), "R6 write miss", "R8 write miss");
        do_op(0, 1, mk(3, 3, 1), "R6 write hit", "R8 write miss no allocate");
        do_op(0, 0, mk(3, 3, 2), "R6 allocated by write", "R8 read miss");
        do_op(0, 1, mk(3, 3, 2), "R6 write hit", "R8 write hit");
        for (int t = 4; t <= 7; t++) do_op(0, 0, mk(t, 3, 0), "R7 fill toward eviction", "R8 fill");

        // R9/R10: prefetch marking and repeated prefetch
        do_op(1, 0, mk(7, 1, 0), "R9 prefetch fill", "R9 prefetch fill");
        do_op(0, 0, mk(7, 1, 4), "R9 prefetched hit", "R9 prefetched hit");
        do_op(0, 0, mk(7, 1, 4), "R9 second hit", "R9 second hit");
        do_op(1, 0, mk(7, 1, 0), "R10 present prefetch", "R10 present prefetch");
        do_op(0, 0, mk(7, 1, 8), "R10 mark not restored", "R10 mark not restored");
        do_op(1, 0, mk(8, 1, 0), "R10 prefetch fill", "R10 prefetch fill");
        do_op(1, 0, mk(8, 1, 0), "R10 repeat prefetch", "R10 repeat prefetch");
        do_op(0, 0, mk(8, 1, 0), "R10 single count", "R10 single count");

        // Random mix
        for (int i = 0; i < 600; i++) begin
            int r; int a; bit p; bit w;
            r = int'($urandom_range(99));
            p = (r < 15);
            w = !p && (r < 50);
            a = mk(int'($urandom_range(5)), int'($urandom_range(SETS - 1)), int'($urandom_range(15)));
            do_op(p, w, a, "R5 random hit", "R4 random hit");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule